// File: doc/BRIEF.md
# Microcoded Accumulator Core

This block is a small accumulator processor whose control comes entirely from a stored microprogram. Words are 16 bits wide. An internal main memory holds 2048 words. The architectural registers are the accumulator and the data register, both 16 bits, plus an 11-bit address register and an 11-bit program counter. A 128-word control store supplies 20-bit microinstructions. Each microinstruction has three independent 3-bit operation fields, a 2-bit condition select, a 2-bit branch kind and a 7-bit next address. The three operation fields are decoded in parallel, so a single microinstruction can read memory and advance the program counter in the same micro-cycle.

A machine instruction has three parts. Bit 15 is the indirect flag, bits 14..11 are the opcode and bits 10..0 are the address. Four instructions are microcoded: add to accumulator (opcode 0000), branch when the accumulator is negative (0001), store the accumulator (0010) and swap the accumulator with memory (0011). Every instruction begins with a shared fetch routine at control address 64. That routine dispatches to control address `opcode*4`. When the indirect flag is set, each routine first calls a shared indirection subroutine at control address 67, and each routine ends by jumping back to 64. The surrounding system fills memory through a load port while the core is halted and then raises `run`. A combinational peek port reads any memory word.

The next-address logic has four named sources, picked from the branch field:
- **INC** steps to CAR+1 when a jump or call condition is false.
- **JMP** takes the address field when the condition is true.
- **RET** takes the saved return address.
- **MAP** forms the dispatch address from the opcode.

The condition select picks one of four tests: always true, the data register's bit 15, the accumulator's sign, or the accumulator being zero.

Top module: `mc_accum_core`

## Requirements
- R1: After reset the accumulator, data register, address register and program counter are zero, and the control address (`car_o`) is 64.
- R2: Fetch takes three micro-cycles (64, 65, 66) and increments the program counter by one. The dispatch then lands on control address `{0, opcode, 00}`; for example opcode 0011 lands on 12.
- R3: ADD (opcode 0000) sets AC to AC + M[EA], modulo 2^16, and takes 3 micro-cycles after fetch when direct.
- R4: BRANCH (opcode 0001) loads PC with EA when AC bit 15 is 1 (3 micro-cycles when direct). When AC bit 15 is 0 the program counter is left unchanged (2 micro-cycles).
- R5: STORE (opcode 0010) writes AC to M[EA] and leaves AC unchanged, taking 3 micro-cycles when direct.
- R6: EXCHANGE (opcode 0011) swaps AC and M[EA] in 4 micro-cycles when direct.
- R7: With instruction bit 15 set, EA is bits 10..0 of M[address field]. Indirection adds exactly 2 micro-cycles.
- R8: Every instruction routine ends with `car_o` back at 64.
- R9: While `run` is low, no register and no control address changes. Load-port writes (`ld_we`) take effect only while `run` is low.
- R10: No microinstruction has more than one of its three operation fields writing the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute one micro-cycle per clock while high |
| ld_we | input | 1 | Memory load strobe, honoured only while halted |
| ld_addr | input | 11 | Memory load address |
| ld_data | input | 16 | Memory load data |
| peek_addr | input | 11 | Memory observation address |
| peek_data | output | 16 | Memory word at `peek_addr` |
| ac_o | output | 16 | Accumulator |
| pc_o | output | 11 | Program counter |
| car_o | output | 7 | Control address register |

## Verification
Two functions can collide in one micro-cycle: the memory read and the program-counter increment in fetch step 65, and the swap step of EXCHANGE, where AC takes DR while DR takes AC. Both are provoked by running EXCHANGE programs, directly and through indirection, and the results are judged from the outputs. The swapped values must appear in AC and in memory with neither one lost. The program counter must have advanced by exactly one. The control address must sit at 64 after an exact micro-cycle count.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 11;
    localparam int CS_AW  = 7;
    localparam int OP_W   = 4;
    localparam logic [CS_AW-1:0] FETCH_ORG = 7'd64;
    localparam logic [CS_AW-1:0] INDIR_ORG = 7'd67;

    typedef enum logic [2:0] {
        F1_NOP, F1_ADD, F1_CLR, F1_INC, F1_DR2AC, F1_DR2AR, F1_PC2AR, F1_WR
    } f1_e;
    typedef enum logic [2:0] {
        F2_NOP, F2_SUB, F2_OR, F2_AND, F2_RD, F2_AC2DR, F2_INCDR, F2_PC2DR
    } f2_e;
    typedef enum logic [2:0] {
        F3_NOP, F3_XOR, F3_NOT, F3_SHL, F3_SHR, F3_INCPC, F3_AR2PC, F3_RSV
    } f3_e;
    typedef enum logic [1:0] {CD_ONE, CD_IND, CD_SIGN, CD_ZERO} cd_e;
    typedef enum logic [1:0] {BR_JMP, BR_CALL, BR_RET, BR_MAP} br_e;

    typedef struct packed {
        f1_e              f1;
        f2_e              f2;
        f3_e              f3;
        cd_e              cd;
        br_e              br;
        logic [CS_AW-1:0] ad;
    } uword_t;
endpackage

// File: rtl/mc_ctrl_store.sv
module mc_ctrl_store
    import mc_pkg::*;
(
    input  logic [CS_AW-1:0] addr,
    output uword_t           word
);
    function automatic uword_t mk(f1_e a, f2_e b, f3_e c, cd_e d, br_e e,
                                  logic [CS_AW-1:0] n);
        uword_t w;
        w.f1 = a; w.f2 = b; w.f3 = c; w.cd = d; w.br = e; w.ad = n;
        return w;
    endfunction

    always_comb begin
        case (addr)
            // add to accumulator
            7'd0:  word = mk(F1_NOP, F2_NOP, F3_NOP, CD_IND, BR_CALL, INDIR_ORG);
            7'd1:  word = mk(F1_NOP, F2_RD, F3_NOP, CD_ONE, BR_JMP, 7'd2);
            7'd2:  word = mk(F1_ADD, F2_NOP, F3_NOP, CD_ONE, BR_JMP, FETCH_ORG);
            // branch on negative
            7'd4:  word = mk(F1_NOP, F2_NOP, F3_NOP, CD_SIGN, BR_JMP, 7'd6);
            7'd5:  word = mk(F1_NOP, F2_NOP, F3_NOP, CD_ONE, BR_JMP, FETCH_ORG);
            7'd6:  word = mk(F1_NOP, F2_NOP, F3_NOP, CD_IND, BR_CALL, INDIR_ORG);
            7'd7:  word = mk(F1_NOP, F2_NOP, F3_AR2PC, CD_ONE, BR_JMP, FETCH_ORG);
            // store accumulator
            7'd8:  word = mk(F1_NOP, F2_NOP, F3_NOP, CD_IND, BR_CALL, INDIR_ORG);
            7'd9:  word = mk(F1_NOP, F2_AC2DR, F3_NOP, CD_ONE, BR_JMP, 7'd10);
            7'd10: word = mk(F1_WR, F2_NOP, F3_NOP, CD_ONE, BR_JMP, FETCH_ORG);
            // swap accumulator and memory
            7'd12: word = mk(F1_NOP, F2_NOP, F3_NOP, CD_IND, BR_CALL, INDIR_ORG);
            7'd13: word = mk(F1_NOP, F2_RD, F3_NOP, CD_ONE, BR_JMP, 7'd14);
            7'd14: word = mk(F1_DR2AC, F2_AC2DR, F3_NOP, CD_ONE, BR_JMP, 7'd15);
            7'd15: word = mk(F1_WR, F2_NOP, F3_NOP, CD_ONE, BR_JMP, FETCH_ORG);
            // fetch
            7'd64: word = mk(F1_PC2AR, F2_NOP, F3_NOP, CD_ONE, BR_JMP, 7'd65);
            7'd65: word = mk(F1_NOP, F2_RD, F3_INCPC, CD_ONE, BR_JMP, 7'd66);
            7'd66: word = mk(F1_DR2AR, F2_NOP, F3_NOP, CD_ONE, BR_MAP, '0);
            // indirection subroutine
            7'd67: word = mk(F1_NOP, F2_RD, F3_NOP, CD_ONE, BR_JMP, 7'd68);
            7'd68: word = mk(F1_DR2AR, F2_NOP, F3_NOP, CD_ONE, BR_RET, '0);
            default: word = mk(F1_NOP, F2_NOP, F3_NOP, CD_ONE, BR_JMP, FETCH_ORG);
        endcase
    end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  uword_t           uw,
    input  logic             ind_bit,
    input  logic             ac_sign,
    input  logic             ac_zero,
    input  logic [OP_W-1:0]  opcode,
    output logic [CS_AW-1:0] car
);
    localparam int PAD_W = CS_AW - OP_W - 2;

    typedef enum logic [1:0] {NA_INC, NA_JMP, NA_RET, NA_MAP} na_src_e;

    logic [CS_AW-1:0] sbr_q;
    logic [CS_AW-1:0] car_n;
    logic [CS_AW-1:0] car_inc;
    logic             cond;
    logic             save_ret;
    na_src_e          src;

    assign car_inc = car + 1'b1;

    always_comb begin
        unique case (uw.cd)
            CD_ONE:  cond = 1'b1;
            CD_IND:  cond = ind_bit;
            CD_SIGN: cond = ac_sign;
            CD_ZERO: cond = ac_zero;
        endcase
    end

    always_comb begin
        save_ret = 1'b0;
        unique case (uw.br)
            BR_JMP:  src = cond ? NA_JMP : NA_INC;
            BR_CALL: begin
                src      = cond ? NA_JMP : NA_INC;
                save_ret = cond;
            end
            BR_RET:  src = NA_RET;
            BR_MAP:  src = NA_MAP;
        endcase
    end

    always_comb begin
        unique case (src)
            NA_INC: car_n = car_inc;
            NA_JMP: car_n = uw.ad;
            NA_RET: car_n = sbr_q;
            NA_MAP: car_n = {{PAD_W{1'b0}}, opcode, 2'b00};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car   <= FETCH_ORG;
            sbr_q <= '0;
        end else if (run) begin
            car <= car_n;
            if (save_ret) sbr_q <= car_inc;
        end
    end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  f1_e               f1,
    input  f2_e               f2,
    input  f3_e               f3,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [DATA_W-1:0] ac,
    output logic [DATA_W-1:0] dr,
    output logic [ADDR_W-1:0] pc,
    output logic [2:0]        ac_wr
);
    logic [DATA_W-1:0] mem [MEM_WORDS];
    logic [ADDR_W-1:0] ar;
    logic [DATA_W-1:0] ac_n, dr_n, rd_word;
    logic [ADDR_W-1:0] ar_n, pc_n;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [DATA_W-1:0] mem_wd;

    assign rd_word   = mem[ar];
    assign peek_data = mem[peek_addr];

    // which field writes the accumulator this micro-cycle
    assign ac_wr[0] = (f1 inside {F1_ADD, F1_CLR, F1_INC, F1_DR2AC});
    assign ac_wr[1] = (f2 inside {F2_SUB, F2_OR, F2_AND});
    assign ac_wr[2] = (f3 inside {F3_XOR, F3_NOT, F3_SHL, F3_SHR});

    always_comb begin
        ac_n = ac;
        case (f3)
            F3_XOR:  ac_n = ac ^ dr;
            F3_NOT:  ac_n = ~ac;
            F3_SHL:  ac_n = ac << 1;
            F3_SHR:  ac_n = ac >> 1;
            default: ;
        endcase
        case (f2)
            F2_SUB:  ac_n = ac - dr;
            F2_OR:   ac_n = ac | dr;
            F2_AND:  ac_n = ac & dr;
            default: ;
        endcase
        case (f1)
            F1_ADD:   ac_n = ac + dr;
            F1_CLR:   ac_n = '0;
            F1_INC:   ac_n = ac + 1'b1;
            F1_DR2AC: ac_n = dr;
            default:  ;
        endcase
    end

    always_comb begin
        dr_n = dr;
        case (f2)
            F2_RD:    dr_n = rd_word;
            F2_AC2DR: dr_n = ac;
            F2_INCDR: dr_n = dr + 1'b1;
            F2_PC2DR: dr_n[ADDR_W-1:0] = pc;
            default:  ;
        endcase
    end

    always_comb begin
        ar_n = ar;
        case (f1)
            F1_DR2AR: ar_n = dr[ADDR_W-1:0];
            F1_PC2AR: ar_n = pc;
            default:  ;
        endcase
        pc_n = pc;
        case (f3)
            F3_INCPC: pc_n = pc + 1'b1;
            F3_AR2PC: pc_n = ar;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac <= '0;
            dr <= '0;
            ar <= '0;
            pc <= '0;
        end else if (run) begin
            ac <= ac_n;
            dr <= dr_n;
            ar <= ar_n;
            pc <= pc_n;
        end
    end

    always_comb begin
        if (run) begin
            mem_we = (f1 == F1_WR);
            mem_wa = ar;
            mem_wd = dr;
        end else begin
            mem_we = ld_we;
            mem_wa = ld_addr;
            mem_wd = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= mem_wd;
    end
endmodule

// File: rtl/mc_accum_core.sv
module mc_accum_core
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [DATA_W-1:0] ac_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [CS_AW-1:0]  car_o
);
    uword_t            uw;
    logic [DATA_W-1:0] dr;
    logic [2:0]        ac_wr;

    mc_ctrl_store u_cs (
        .addr (car_o),
        .word (uw)
    );

    mc_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .uw      (uw),
        .ind_bit (dr[DATA_W-1]),
        .ac_sign (ac_o[DATA_W-1]),
        .ac_zero (ac_o == '0),
        .opcode  (dr[DATA_W-2 -: OP_W]),
        .car     (car_o)
    );

    mc_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .f1        (uw.f1),
        .f2        (uw.f2),
        .f3        (uw.f3),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .ac        (ac_o),
        .dr        (dr),
        .pc        (pc_o),
        .ac_wr     (ac_wr)
    );
endmodule

// File: rtl/mc_accum_core_chk.sv
module mc_accum_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic [6:0]  car,
    input logic [10:0] pc,
    input logic [15:0] ac,
    input logic [2:0]  ac_wr
);
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && car == 7'd64) |=> (car == 7'd65));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && car == 7'd65) |=> (pc == $past(pc) + 11'd1));

    assert_map_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && car == 7'd66) |=> (car[6] == 1'b0 && car[1:0] == 2'b00));

    assert_routine_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && car inside {7'd2, 7'd5, 7'd7, 7'd10, 7'd15}) |=> (car == 7'd64));

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(ac) && $stable(pc) && $stable(car)));

    assert_one_ac_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ac_wr));
endmodule

bind mc_accum_core mc_accum_core_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .car   (car_o),
    .pc    (pc_o),
    .ac    (ac_o),
    .ac_wr (ac_wr)
);

// File: tb/tb_mc_accum_core.sv
module tb_mc_accum_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        ld_we = 1'b0;
    logic [10:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [10:0] peek_addr = '0;
    logic [15:0] peek_data;
    logic [15:0] ac_o;
    logic [10:0] pc_o;
    logic [6:0]  car_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_accum_core dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .ac_o(ac_o), .pc_o(pc_o), .car_o(car_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        ind;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] exp_ac;
        logic [15:0] exp_m;
        logic [10:0] exp_pc;
        logic [7:0]  ncyc;
    } vec_t;

    // op, indirect, M[100], M[101], AC, M[101] after, PC, micro-cycles
    localparam vec_t VEC [9] = '{
        '{4'd0, 1'b0, 16'h0005, 16'h0007, 16'h000C, 16'h0007, 11'd2,   8'd12},
        '{4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0001, 11'd2,   8'd12},
        '{4'd1, 1'b0, 16'h8000, 16'h0009, 16'h8000, 16'h0009, 11'd101, 8'd12},
        '{4'd1, 1'b0, 16'h7FFF, 16'h0009, 16'h7FFF, 16'h0009, 11'd2,   8'd11},
        '{4'd2, 1'b0, 16'h1234, 16'h0000, 16'h1234, 16'h1234, 11'd2,   8'd12},
        '{4'd3, 1'b0, 16'hABCD, 16'h0042, 16'h0042, 16'hABCD, 11'd2,   8'd13},
        '{4'd0, 1'b1, 16'h0003, 16'h0004, 16'h0007, 16'h0004, 11'd2,   8'd14},
        '{4'd3, 1'b1, 16'h0001, 16'h0002, 16'h0002, 16'h0001, 11'd2,   8'd15},
        '{4'd1, 1'b1, 16'h8001, 16'h0005, 16'h8001, 16'h0005, 11'd101, 8'd14}
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(logic [10:0] a, logic [15:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic step(int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic peek(logic [10:0] a, output logic [15:0] d);
        peek_addr = a;
        #1;
        d = peek_data;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] m;
        do_reset();
        // R1 reset state
        check("R1 ac", ac_o, 16'h0000);
        check("R1 pc", {5'd0, pc_o}, 16'h0000);
        check("R1 car", {9'd0, car_o}, 16'd64);

        // table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 9; i++) begin
            do_reset();
            load(11'd0, {1'b0, 4'd0, 11'd100});
            load(11'd1, {VEC[i].ind, VEC[i].op, VEC[i].ind ? 11'd102 : 11'd101});
            load(11'd100, VEC[i].x);
            load(11'd101, VEC[i].y);
            load(11'd102, 16'd101);
            step(int'(VEC[i].ncyc));
            peek(11'd101, m);
            check("R3/R4/R5/R6/R7 ac", ac_o, VEC[i].exp_ac);
            check("R5/R6 mem", m, VEC[i].exp_m);
            check("R4 pc", {5'd0, pc_o}, {5'd0, VEC[i].exp_pc});
            check("R8 car", {9'd0, car_o}, 16'd64);
        end

        // R9 halt freezes state, load port works while halted
        begin
            logic [15:0] ac0;
            logic [10:0] pc0;
            ac0 = ac_o; pc0 = pc_o;
            load(11'd500, 16'h5A5A);
            repeat (4) @(negedge clk);
            peek(11'd500, m);
            check("R9 ac frozen", ac_o, ac0);
            check("R9 pc frozen", {5'd0, pc_o}, {5'd0, pc0});
            check("R9 car frozen", {9'd0, car_o}, 16'd64);
            check("R9 halted load", m, 16'h5A5A);
        end

        // R2 fetch dispatch with opcode 0011
        do_reset();
        load(11'd0, {1'b0, 4'd3, 11'd100});
        step(3);
        check("R2 dispatch", {9'd0, car_o}, 16'd12);
        check("R2 pc step", {5'd0, pc_o}, 16'd1);

        // R9 load strobe ignored while running
        do_reset();
        load(11'd600, 16'h1111);
        @(negedge clk);
        run = 1'b1; ld_we = 1'b1; ld_addr = 11'd600; ld_data = 16'h2222;
        @(negedge clk);
        run = 1'b0; ld_we = 1'b0;
        peek(11'd600, m);
        check("R9 running load ignored", m, 16'h1111);
        check("R2 first fetch step", {9'd0, car_o}, 16'd65);

        // R1 reset in mid-routine
        step(2);
        do_reset();
        check("R1 car after mid reset", {9'd0, car_o}, 16'd64);
        check("R1 pc after mid reset", {5'd0, pc_o}, 16'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule